// File: doc/BRIEF.md
# Snooping MESI Cache Coherence Controller

This block is the coherence controller that sits beside one processor in a small multiprocessor where all caches share a single bus. It holds the state, tag and data of a direct-mapped cache and serves processor loads and stores. Each line carries one of four coherence states: modified, exclusive, shared or invalid.

When the local cache cannot complete an access by itself, the controller asks for the bus and issues a fill read, a read-for-ownership or an ownership invalidate. A dirty victim is written back before the fill that replaces it. The controller also watches every transaction that the other caches place on the bus. It reports that it holds the line on a wired-OR style signal, and it drives the line's data when it holds the only up-to-date copy. It downgrades or drops its own copy as the protocol requires.

Every bus transaction completes in the cycle in which the arbiter grants it. Snooped transactions are presented one per cycle and never in a cycle that grants this controller the bus. The processor holds its request until the controller raises a one-cycle ready.

Top module: `mesi_snoop_cache`

## Requirements
- R1: After reset every line is invalid, no bus request is raised, the processor ready output is low, and no snoop reports a hit.
- R2: A load miss issues a fill read (bus command 1). The line is installed exclusive when bus_shared_in is low and shared when it is high. The load returns the bus data in the cycle after the grant.
- R3: A load that hits a valid line, or a store that hits an exclusive or modified line, completes with no bus transaction. Such a store leaves the line modified.
- R4: A store that hits a shared line issues one invalidate (bus command 3) for its address before completing, and leaves the line modified.
- R5: A miss whose victim line is modified first issues a writeback (bus command 0) carrying the victim's address (tag above index) and data, then the fill. A clean victim is dropped without a writeback.
- R6: A snooped read (command 1) that hits raises snp_hit. If the line is modified, the controller also raises snp_supply and drives the line's data. A modified or exclusive line moves to shared.
- R7: A snooped read-for-ownership (command 2) or invalidate (command 3) that hits any valid line raises snp_hit and moves the line to invalid. A modified line also supplies its data on a read-for-ownership.
- R8: A snooped writeback (command 0) raises no hit or supply and leaves the line unchanged.
- R9: While waiting for the grant, the pending request is re-planned after every snoop. A victim that a snoop has downgraded from modified skips its writeback. A pending invalidate turns into a read-for-ownership if a snoop has taken the line away.
- R10: cpu_ready is high for exactly one cycle per request. cpu_rdata is valid while cpu_ready is high. A request is held off while a bus transaction is pending.
- R11: A processor request and a snoop to the same line index in the same cycle are resolved snoop first. The processor access is then served against the line state the snoop left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_valid | input | 1 | Processor request present; held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address; low INDEX_W bits select the line, the rest is the tag |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_ready |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Grant; the transaction completes in the granted cycle |
| bus_cmd | output | 2 | 0 writeback, 1 read, 2 read-for-ownership, 3 invalidate |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_rdata | input | DATA_W | Fill data from memory or the supplying cache |
| bus_shared_in | input | 1 | Another cache holds the line being read |
| snp_valid | input | 1 | A transaction by another cache is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_hit | output | 1 | This cache holds the snooped line (shared signal contribution) |
| snp_supply | output | 1 | This cache drives the line data instead of memory |
| snp_data | output | DATA_W | Supplied line data |

## Verification
The bench aims at the places where a controller goes wrong in ways that are easy to overlook. One is a fill that ignores the shared signal: the line is then installed exclusive, and a later store completes silently instead of invalidating the other copies. Another is a dirty victim evicted without its writeback, which would leave stale memory that a later miss reads back. The bench also holds off the grant while a snoop changes the very line a request is waiting on. A controller that plans its command only once would then write back a line that is already clean, or send an invalidate for a line it no longer holds. A same-cycle clash between a store and a snooped read-for-ownership checks that the store is redone as a miss rather than upgrading a copy that has already been taken away. A long pseudo-random sweep over four lines and four tags, checked against a reference state model kept in the bench, covers the remaining state and command pairs.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    typedef enum logic [1:0] {
        CMD_WB  = 2'd0,
        CMD_RD  = 2'd1,
        CMD_RDX = 2'd2,
        CMD_INV = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BUS  = 2'd1,
        PH_RESP = 2'd2
    } phase_t;

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int INDEX_W = 2,
    parameter int TAG_W   = 6,
    parameter int DATA_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_a_idx,
    output mesi_t              rd_a_state,
    output logic [TAG_W-1:0]   rd_a_tag,
    output logic [DATA_W-1:0]  rd_a_data,
    input  logic [INDEX_W-1:0] rd_b_idx,
    output mesi_t              rd_b_state,
    output logic [TAG_W-1:0]   rd_b_tag,
    output logic [DATA_W-1:0]  rd_b_data,
    input  logic               wf_en,
    input  logic [INDEX_W-1:0] wf_idx,
    input  mesi_t              wf_state,
    input  logic [TAG_W-1:0]   wf_tag,
    input  logic [DATA_W-1:0]  wf_data,
    input  logic               ws_en,
    input  logic [INDEX_W-1:0] ws_idx,
    input  mesi_t              ws_state
);

    localparam int LINES = 1 << INDEX_W;

    typedef struct packed {
        mesi_t              st;
        logic [TAG_W-1:0]   tag;
        logic [DATA_W-1:0]  data;
    } line_t;

    line_t lines_q [LINES];
    line_t lines_d [LINES];

    // Full-line port (processor/bus side) wins over the state-only snoop port;
    // the controller keeps them on distinct lines.
    always_comb begin
        for (int i = 0; i < LINES; i++) begin
            lines_d[i] = lines_q[i];
            if (ws_en && ws_idx == INDEX_W'(i)) begin
                lines_d[i].st = ws_state;
            end
            if (wf_en && wf_idx == INDEX_W'(i)) begin
                lines_d[i].st   = wf_state;
                lines_d[i].tag  = wf_tag;
                lines_d[i].data = wf_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        for (int i = 0; i < LINES; i++) begin
            if (!rst_n) begin
                lines_q[i] <= '{st: ST_I, tag: '0, data: '0};
            end else begin
                lines_q[i] <= lines_d[i];
            end
        end
    end

    assign rd_a_state = lines_q[rd_a_idx].st;
    assign rd_a_tag   = lines_q[rd_a_idx].tag;
    assign rd_a_data  = lines_q[rd_a_idx].data;
    assign rd_b_state = lines_q[rd_b_idx].st;
    assign rd_b_tag   = lines_q[rd_b_idx].tag;
    assign rd_b_data  = lines_q[rd_b_idx].data;

    // R11: a snoop update and a processor/bus update never target one line together
    a_r11_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        !(wf_en && ws_en && wf_idx == ws_idx));

endmodule

// File: rtl/mesi_snoop_resp.sv
module mesi_snoop_resp
    import mesi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             snp_valid,
    input  bus_cmd_t         snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  mesi_t            line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             hit,
    output logic             supply,
    output logic             upd_en,
    output mesi_t            upd_st
);

    logic holds;

    always_comb begin
        holds  = snp_valid && (line_st != ST_I) && (line_tag == snp_tag);
        hit    = 1'b0;
        supply = 1'b0;
        upd_en = 1'b0;
        upd_st = line_st;
        unique case (snp_cmd)
            CMD_RD: begin
                hit    = holds;
                supply = holds && (line_st == ST_M);
                upd_en = holds && (line_st == ST_M || line_st == ST_E);
                upd_st = ST_S;
            end
            CMD_RDX: begin
                hit    = holds;
                supply = holds && (line_st == ST_M);
                upd_en = holds;
                upd_st = ST_I;
            end
            CMD_INV: begin
                hit    = holds;
                upd_en = holds;
                upd_st = ST_I;
            end
            default: begin
                // snooped writebacks leave this cache untouched
            end
        endcase
    end

endmodule

// File: rtl/mesi_req_plan.sv
module mesi_req_plan
    import mesi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             req_we,
    input  logic [TAG_W-1:0] req_tag,
    input  mesi_t            line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             local_ok,
    output bus_cmd_t         cmd,
    output logic             victim
);

    logic tag_hit;

    always_comb begin
        tag_hit  = (line_st != ST_I) && (line_tag == req_tag);
        local_ok = 1'b0;
        victim   = 1'b0;
        cmd      = CMD_RD;
        if (tag_hit) begin
            if (!req_we || line_st == ST_E || line_st == ST_M) begin
                local_ok = 1'b1;
            end else begin
                cmd = CMD_INV;
            end
        end else if (line_st == ST_M) begin
            cmd    = CMD_WB;
            victim = 1'b1;
        end else begin
            cmd = req_we ? CMD_RDX : CMD_RD;
        end
    end

endmodule

// File: rtl/mesi_snoop_cache.sv
module mesi_snoop_cache
    import mesi_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int INDEX_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_hit,
    output logic              snp_supply,
    output logic [DATA_W-1:0] snp_data
);

    localparam int TAG_W = ADDR_W - INDEX_W;

    typedef struct packed {
        phase_t             ph;
        logic               pend_we;
        logic [ADDR_W-1:0]  pend_addr;
        logic [DATA_W-1:0]  pend_wdata;
        logic [DATA_W-1:0]  rdata;
    } ctl_t;

    ctl_t c_q, c_d;

    logic [ADDR_W-1:0]  cur_addr;
    logic               cur_we;
    logic [INDEX_W-1:0] cur_idx;
    logic [TAG_W-1:0]   cur_tag;
    logic [INDEX_W-1:0] snp_idx;
    logic [TAG_W-1:0]   snp_tag;

    mesi_t              a_state, b_state;
    logic [TAG_W-1:0]   a_tag, b_tag;
    logic [DATA_W-1:0]  a_data, b_data;

    logic               wf_en;
    mesi_t              wf_state;
    logic [TAG_W-1:0]   wf_tag;
    logic [DATA_W-1:0]  wf_data;
    logic               ws_en;
    mesi_t              ws_state;

    logic               p_local, p_victim;
    bus_cmd_t           p_cmd;
    logic               clash;

    // In IDLE the live processor inputs are planned; afterwards the latched request.
    assign cur_addr = (c_q.ph == PH_IDLE) ? cpu_addr : c_q.pend_addr;
    assign cur_we   = (c_q.ph == PH_IDLE) ? cpu_we   : c_q.pend_we;
    assign cur_idx  = cur_addr[INDEX_W-1:0];
    assign cur_tag  = cur_addr[ADDR_W-1:INDEX_W];
    assign snp_idx  = snp_addr[INDEX_W-1:0];
    assign snp_tag  = snp_addr[ADDR_W-1:INDEX_W];
    assign clash    = snp_valid && (snp_idx == cur_idx);

    mesi_line_store #(
        .INDEX_W (INDEX_W),
        .TAG_W   (TAG_W),
        .DATA_W  (DATA_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_a_idx   (cur_idx),
        .rd_a_state (a_state),
        .rd_a_tag   (a_tag),
        .rd_a_data  (a_data),
        .rd_b_idx   (snp_idx),
        .rd_b_state (b_state),
        .rd_b_tag   (b_tag),
        .rd_b_data  (b_data),
        .wf_en      (wf_en),
        .wf_idx     (cur_idx),
        .wf_state   (wf_state),
        .wf_tag     (wf_tag),
        .wf_data    (wf_data),
        .ws_en      (ws_en),
        .ws_idx     (snp_idx),
        .ws_state   (ws_state)
    );

    mesi_snoop_resp #(
        .TAG_W (TAG_W)
    ) u_snoop (
        .snp_valid (snp_valid),
        .snp_cmd   (bus_cmd_t'(snp_cmd)),
        .snp_tag   (snp_tag),
        .line_st   (b_state),
        .line_tag  (b_tag),
        .hit       (snp_hit),
        .supply    (snp_supply),
        .upd_en    (ws_en),
        .upd_st    (ws_state)
    );

    mesi_req_plan #(
        .TAG_W (TAG_W)
    ) u_plan (
        .req_we   (cur_we),
        .req_tag  (cur_tag),
        .line_st  (a_state),
        .line_tag (a_tag),
        .local_ok (p_local),
        .cmd      (p_cmd),
        .victim   (p_victim)
    );

    assign snp_data = b_data;

    always_comb begin
        c_d      = c_q;
        wf_en    = 1'b0;
        wf_state = ST_M;
        wf_tag   = cur_tag;
        wf_data  = c_q.pend_wdata;
        unique case (c_q.ph)
            PH_IDLE: begin
                if (cpu_valid && !clash) begin
                    c_d.pend_we    = cpu_we;
                    c_d.pend_addr  = cpu_addr;
                    c_d.pend_wdata = cpu_wdata;
                    if (p_local) begin
                        if (cpu_we) begin
                            wf_en   = 1'b1;
                            wf_data = cpu_wdata;
                        end else begin
                            c_d.rdata = a_data;
                        end
                        c_d.ph = PH_RESP;
                    end else begin
                        c_d.ph = PH_BUS;
                    end
                end
            end
            PH_BUS: begin
                if (bus_gnt) begin
                    wf_en = 1'b1;
                    unique case (p_cmd)
                        CMD_WB: begin
                            wf_state = ST_I;
                            wf_tag   = a_tag;
                            wf_data  = a_data;
                        end
                        CMD_RD: begin
                            wf_state  = bus_shared_in ? ST_S : ST_E;
                            wf_data   = bus_rdata;
                            c_d.rdata = bus_rdata;
                            c_d.ph    = PH_RESP;
                        end
                        default: begin
                            c_d.ph = PH_RESP;
                        end
                    endcase
                end
            end
            default: begin
                c_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{ph: PH_IDLE, pend_we: 1'b0, pend_addr: '0, pend_wdata: '0, rdata: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign bus_req   = (c_q.ph == PH_BUS);
    assign bus_cmd   = p_cmd;
    assign bus_addr  = p_victim ? {a_tag, cur_idx} : cur_addr;
    assign bus_wdata = a_data;
    assign cpu_ready = (c_q.ph == PH_RESP);
    assign cpu_rdata = c_q.rdata;

    // R10: completion is a single-cycle pulse
    a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R10: an ungranted request persists while no snoop disturbs it
    a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid) |=> bus_req);

    // R5: a writeback is always followed by the fill request
    a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == 2'd0) |=> bus_req);

    // R2: a granted fill read returns its data in the next cycle
    a_r2_fill_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == 2'd1) |=> (cpu_ready && cpu_rdata == $past(bus_rdata)));

    // R4: a granted invalidate completes the store
    a_r4_inv_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == 2'd3) |=> cpu_ready);

    // R6/R7: data is supplied only for snooped reads of either kind
    a_r7_supply_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_hit && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));

    // R9: the shared bus never snoops and grants this cache in one cycle
    a_r9_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_gnt && snp_valid));

endmodule

// File: tb/test_mesi_snoop_cache.sv
module test_mesi_snoop_cache;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_valid = 1'b0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_ready;
    logic [7:0] cpu_rdata;
    logic       bus_req;
    logic       bus_gnt;
    logic [1:0] bus_cmd;
    logic [7:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       others_share = 1'b0;
    logic       gnt_en = 1'b1;
    logic       snp_valid = 1'b0;
    logic [1:0] snp_cmd = '0;
    logic [7:0] snp_addr = '0;
    logic       snp_hit;
    logic       snp_supply;
    logic [7:0] snp_data;

    int total = 0;
    int fails = 0;

    logic [7:0] mem [256];
    int         txn_cnt = 0;
    logic [1:0] last_cmd = '0;
    logic [1:0] prev_cmd = '0;

    // reference model: 0 I, 1 S, 2 E, 3 M
    int         m_st  [4];
    logic [5:0] m_tag [4];
    logic [7:0] m_dat [4];

    always #5 clk = ~clk;

    assign bus_gnt   = bus_req & gnt_en;
    assign bus_rdata = mem[bus_addr];

    mesi_snoop_cache i_mesi_snoop_cache (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_valid     (cpu_valid),
        .cpu_we        (cpu_we),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_ready     (cpu_ready),
        .cpu_rdata     (cpu_rdata),
        .bus_req       (bus_req),
        .bus_gnt       (bus_gnt),
        .bus_cmd       (bus_cmd),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_shared_in (others_share),
        .snp_valid     (snp_valid),
        .snp_cmd       (snp_cmd),
        .snp_addr      (snp_addr),
        .snp_hit       (snp_hit),
        .snp_supply    (snp_supply),
        .snp_data      (snp_data)
    );

    // memory and bus log
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else begin
            if (bus_req && bus_gnt) begin
                prev_cmd <= last_cmd;
                last_cmd <= bus_cmd;
                txn_cnt  <= txn_cnt + 1;
                if (bus_cmd == 2'd0) mem[bus_addr] <= bus_wdata;
            end
            if (snp_valid && snp_supply) mem[snp_addr] <= snp_data;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic raw_cpu(input logic we, input logic [7:0] a, input logic [7:0] d,
                           output logic [7:0] q);
        int n;
        @(negedge clk);
        cpu_valid = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = d;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_ready && n < 2000);
        if (!cpu_ready) chk(1'b0, "R10", "request never completed", 0, 1);
        q = cpu_rdata;
        cpu_valid = 1'b0;
    endtask

    task automatic raw_snoop(input logic [1:0] c, input logic [7:0] a,
                             output logic h, output logic s, output logic [7:0] d);
        @(negedge clk);
        snp_valid = 1'b1;
        snp_cmd   = c;
        snp_addr  = a;
        #1;
        h = snp_hit;
        s = snp_supply;
        d = snp_data;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic ld(input logic [7:0] a, input logic sh);
        logic [1:0] ix = a[1:0];
        logic [5:0] tg = a[7:2];
        bit hit, vdirty;
        int exp_tx, t0;
        logic [7:0] exp_d, got, vaddr, vdat;
        string rq;
        hit    = (m_st[ix] != 0) && (m_tag[ix] == tg);
        vdirty = !hit && (m_st[ix] == 3);
        vaddr  = {m_tag[ix], ix};
        vdat   = m_dat[ix];
        exp_tx = hit ? 0 : (vdirty ? 2 : 1);
        exp_d  = hit ? m_dat[ix] : mem[a];
        rq     = hit ? "R3" : "R2";
        others_share = sh;
        t0 = txn_cnt;
        raw_cpu(1'b0, a, 8'h00, got);
        chk(got == exp_d, rq, "load data", got, exp_d);
        chk(txn_cnt - t0 == exp_tx, rq, "load bus transactions", txn_cnt - t0, exp_tx);
        if (vdirty) begin
            chk(mem[vaddr] == vdat, "R5", "written-back victim data", mem[vaddr], vdat);
            chk(prev_cmd == 2'd0, "R5", "writeback precedes fill", prev_cmd, 0);
        end
        if (!hit) begin
            m_st[ix]  = sh ? 1 : 2;
            m_tag[ix] = tg;
            m_dat[ix] = exp_d;
        end
    endtask

    task automatic st(input logic [7:0] a, input logic [7:0] d);
        logic [1:0] ix = a[1:0];
        logic [5:0] tg = a[7:2];
        bit hit, vdirty;
        int exp_tx, t0, exp_cmd;
        logic [7:0] got, vaddr, vdat;
        string rq;
        hit    = (m_st[ix] != 0) && (m_tag[ix] == tg);
        vdirty = !hit && (m_st[ix] == 3);
        vaddr  = {m_tag[ix], ix};
        vdat   = m_dat[ix];
        if (hit && m_st[ix] >= 2) begin
            exp_tx = 0; exp_cmd = 0; rq = "R3";
        end else if (hit) begin
            exp_tx = 1; exp_cmd = 3; rq = "R4";
        end else begin
            exp_tx = vdirty ? 2 : 1; exp_cmd = 2; rq = "R5";
        end
        t0 = txn_cnt;
        raw_cpu(1'b1, a, d, got);
        chk(txn_cnt - t0 == exp_tx, rq, "store bus transactions", txn_cnt - t0, exp_tx);
        if (exp_tx > 0) chk(last_cmd == 2'(exp_cmd), rq, "store bus command", last_cmd, exp_cmd);
        if (vdirty) chk(mem[vaddr] == vdat, "R5", "written-back victim data", mem[vaddr], vdat);
        m_st[ix]  = 3;
        m_tag[ix] = tg;
        m_dat[ix] = d;
    endtask

    task automatic snp(input logic [1:0] c, input logic [7:0] a);
        logic [1:0] ix = a[1:0];
        logic [5:0] tg = a[7:2];
        bit eh, es;
        logic h, s;
        logic [7:0] d;
        string rq;
        eh = (c != 2'd0) && (m_st[ix] != 0) && (m_tag[ix] == tg);
        es = eh && (m_st[ix] == 3) && (c == 2'd1 || c == 2'd2);
        rq = (c == 2'd1) ? "R6" : ((c == 2'd0) ? "R8" : "R7");
        raw_snoop(c, a, h, s, d);
        chk(h == eh, rq, "snoop hit", h, eh);
        chk(s == es, rq, "snoop supply", s, es);
        if (es) chk(d == m_dat[ix], rq, "supplied data", d, m_dat[ix]);
        if (eh) begin
            if (c == 2'd1) begin
                if (m_st[ix] >= 2) m_st[ix] = 1;
            end else begin
                m_st[ix] = 0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R10", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        logic h, s;
        logic [7:0] d, q, exp;
        int t0;
        logic [31:0] seed;
        for (int i = 0; i < 4; i++) begin
            m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(cpu_ready == 1'b0, "R1", "ready after reset", cpu_ready, 0);
        chk(bus_req == 1'b0, "R1", "bus request after reset", bus_req, 0);
        for (int i = 0; i < 4; i++) begin
            raw_snoop(2'd1, 8'(i), h, s, d);
            chk(h == 1'b0, "R1", "snoop hit after reset", h, 0);
        end

        // exclusive fill, silent upgrade, dirty supply, invalidate upgrade
        ld(8'h10, 1'b0);
        st(8'h10, 8'hA1);
        snp(2'd1, 8'h10);
        chk(mem[8'h10] == 8'hA1, "R6", "memory updated by supply", mem[8'h10], 8'hA1);
        snp(2'd1, 8'h10);
        st(8'h10, 8'hB2);
        ld(8'h10, 1'b0);
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R10", "ready drops after one cycle", cpu_ready, 0);
        snp(2'd2, 8'h10);
        snp(2'd1, 8'h10);

        // shared fill, dirty and clean victims
        ld(8'h20, 1'b1);
        st(8'h20, 8'hC4);
        ld(8'h30, 1'b0);
        ld(8'h30, 1'b0);
        ld(8'h40, 1'b0);
        snp(2'd3, 8'h40);
        ld(8'h40, 1'b0);
        st(8'h40, 8'hC3);

        // R9: victim downgraded by a snoop while the fill waits for grant
        gnt_en = 1'b0;
        others_share = 1'b0;
        exp = mem[8'h80];
        t0 = txn_cnt;
        fork
            raw_cpu(1'b0, 8'h80, 8'h00, q);
            begin
                repeat (3) @(negedge clk);
                chk(bus_req && bus_cmd == 2'd0 && bus_addr == 8'h40, "R5",
                    "writeback pending for dirty victim", {bus_cmd, bus_addr}, 10'h040);
                raw_snoop(2'd1, 8'h40, h, s, d);
                chk(s && d == 8'hC3, "R6", "victim supplies while waiting", {s, d}, 9'h1C3);
                @(negedge clk);
                chk(bus_cmd == 2'd1 && bus_addr == 8'h80, "R9", "replanned to fill without writeback",
                    {bus_cmd, bus_addr}, 10'h180);
                gnt_en = 1'b1;
            end
        join
        chk(txn_cnt - t0 == 1, "R9", "one transaction after downgrade", txn_cnt - t0, 1);
        chk(q == exp, "R9", "fill data", q, exp);
        m_st[0] = 2; m_tag[0] = 6'h20; m_dat[0] = exp;

        // R9: pending invalidate converted after the line is taken away
        snp(2'd1, 8'h80);
        gnt_en = 1'b0;
        t0 = txn_cnt;
        fork
            raw_cpu(1'b1, 8'h80, 8'h77, q);
            begin
                repeat (3) @(negedge clk);
                chk(bus_req && bus_cmd == 2'd3, "R4", "invalidate pending for shared line", bus_cmd, 3);
                raw_snoop(2'd3, 8'h80, h, s, d);
                chk(h && !s, "R7", "invalidate snoop hits without supply", {h, s}, 2'b10);
                @(negedge clk);
                chk(bus_cmd == 2'd2, "R9", "replanned to ownership read", bus_cmd, 2);
                gnt_en = 1'b1;
            end
        join
        chk(txn_cnt - t0 == 1, "R9", "one transaction after loss", txn_cnt - t0, 1);
        m_st[0] = 3; m_dat[0] = 8'h77;
        snp(2'd1, 8'h80);

        // R11: same-cycle store and snooped ownership read on one line
        t0 = txn_cnt;
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h80; cpu_wdata = 8'h99;
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = 8'h80;
        #1;
        chk(snp_hit && !snp_supply, "R11", "snoop served first", {snp_hit, snp_supply}, 2'b10);
        @(negedge clk);
        snp_valid = 1'b0;
        while (!cpu_ready) @(negedge clk);
        cpu_valid = 1'b0;
        chk(txn_cnt - t0 == 1 && last_cmd == 2'd2, "R11", "store redone as ownership read",
            {last_cmd, 8'(txn_cnt - t0)}, 10'h201);
        m_st[0] = 3; m_dat[0] = 8'h99;
        snp(2'd0, 8'h80);
        snp(2'd1, 8'h80);

        // near-exhaustive sweep: 4 lines x 4 tags, all operations
        seed = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            int op;
            logic [7:0] a;
            seed = seed * 32'd1103515245 + 32'd12345;
            op = int'(seed[26:16]) % 7;
            a  = {4'h0, seed[11:8]};
            case (op)
                0: ld(a, 1'b0);
                1: ld(a, 1'b1);
                2: st(a, seed[7:0]);
                3: snp(2'd1, a);
                4: snp(2'd2, a);
                5: snp(2'd3, a);
                default: snp(2'd0, a);
            endcase
        end

        finish_run();
    end

endmodule